// File: doc/BRIEF.md
# Decoder-Controlled Ripple ALU

This block is a small combinational arithmetic-logic unit. Its operands are two words, `op_a` and `op_b`. It also takes a two-bit operation code and an external carry input. It returns a result word and a carry output. The datapath is a chain of identical one-bit cells linked by a ripple carry. Each cell computes a bitwise AND, a bitwise OR and a full-adder sum side by side.

A decoder turns the operation code into one-hot enable lines. Each enable is ANDed with the output of one functional unit, and the gated outputs are ORed onto the result bit. No multiplexer is used. The decoder also drives an XOR stage on the A operand ahead of the adder, together with a carry-force line. With these, the same adder performs addition, and subtraction of A from B. The default width is four bits.

A surrounding datapath drives the operands and the code, and reads the result in the same cycle once the carry chain has settled.

Top module: `ripple_alu4`

## Requirements
- R1: With `func_sel` = 0, `result` equals `op_a & op_b` and `carry_out` is 0.
- R2: With `func_sel` = 1, `result` equals `op_a | op_b` and `carry_out` is 0.
- R3: With `func_sel` = 2, `result` equals `(op_b - op_a) mod 2^WIDTH`, computed as `op_b + ~op_a + 1`. `carry_out` is the carry out of that sum, so it is 1 exactly when `op_b >= op_a`. The carry into the first cell is forced to 1.
- R4: With `func_sel` = 3, `{carry_out, result}` equals `op_a + op_b + carry_in`.
- R5: For every code, exactly one of the three functional-unit enables is active.
- R6: In codes 0, 1 and 2, `carry_in` has no effect on `result` or `carry_out`.
- R7: Each cell's carry input is the carry output of the cell below it. The lowest cell takes the forced or external carry.
- R8: The unit has no storage. The outputs depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_sel | input | 2 | Operation code: 0 AND, 1 OR, 2 B minus A, 3 add with carry |
| op_a | input | WIDTH | Operand A (inverted for subtraction) |
| op_b | input | WIDTH | Operand B |
| carry_in | input | 1 | External carry, used by code 3 only |
| result | output | WIDTH | Selected unit's output word |
| carry_out | output | 1 | Adder carry for codes 2 and 3, otherwise 0 |

## Verification
Every result is due in the same cycle as its stimulus. No register lies between the ports. The bench applies each input set just after a falling clock edge and samples one nanosecond later, well before the next rising edge. Each sample therefore reflects the settled ripple chain for those inputs only. Every code is checked over all operand pairs with both carry values, which covers the `carry_in` cases of R6 and the borrow boundary of R3. Seeded random vectors and a few directed corner cases follow.

// File: rtl/alu_pkg.sv
// Package: shared control type and operation codes for the ripple ALU.
// Assumes a two-bit operation code.
package alu_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_SUB = 2'd2,
        OP_ADD = 2'd3
    } alu_op_e;

    // Control lines produced by the decoder for every cell.
    typedef struct packed {
        logic en_and;     // gate AND unit onto result
        logic en_or;      // gate OR unit onto result
        logic en_sum;     // gate adder sum onto result
        logic inv_a;      // XOR-invert operand A ahead of the adder
        logic force_cin;  // force first carry to 1
    } alu_ctl_t;

endpackage

// File: rtl/alu_op_decoder.sv
// Module: alu_op_decoder
// Turns the operation code into one-hot unit enables plus the adder's
// inversion and carry-force controls. Purely combinational.
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output alu_ctl_t          ctl
);

    // Decode each code into its control pattern.
    always_comb begin
        ctl = '0;
        unique case (alu_op_e'(code))
            OP_AND: ctl.en_and = 1'b1;
            OP_OR:  ctl.en_or  = 1'b1;
            OP_SUB: begin
                ctl.en_sum    = 1'b1;
                ctl.inv_a     = 1'b1;
                ctl.force_cin = 1'b1;
            end
            OP_ADD: ctl.en_sum = 1'b1;
            default: ctl = '0;
        endcase
    end

    // Exactly one functional unit is enabled for every code.
    always_comb begin
        assert_onehot_unit_R5: assert ($countones({ctl.en_and, ctl.en_or, ctl.en_sum}) == 1)
            else $error("decoder enabled %0d units", $countones({ctl.en_and, ctl.en_or, ctl.en_sum}));
        // Inversion and carry forcing only ever accompany the adder.
        assert_inv_with_sum_R3: assert (!(ctl.inv_a || ctl.force_cin) || ctl.en_sum)
            else $error("inversion active without adder enable");
    end

endmodule

// File: rtl/alu_bit_cell.sv
// Module: alu_bit_cell
// One-bit ALU cell. Computes AND, OR and a full-adder sum side by side,
// with operand A passed through an XOR inverter. Enable lines AND-gate each
// unit onto the result. Assumes the enables are one-hot.
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     cin,
    input  alu_ctl_t ctl,
    output logic     r,
    output logic     cout
);

    logic a_adj;
    logic and_u;
    logic or_u;
    logic sum_u;

    // Independent logic units and the XOR stage ahead of the adder.
    always_comb begin
        and_u = a & b;
        or_u  = a | b;
        a_adj = a ^ ctl.inv_a;
    end

    // Full adder on the adjusted operand.
    always_comb begin
        sum_u = a_adj ^ b ^ cin;
        cout  = (a_adj & b) | (cin & (a_adj ^ b));
    end

    // Enable gating: each unit passes through its own AND gate.
    always_comb begin
        r = (ctl.en_and & and_u) | (ctl.en_or & or_u) | (ctl.en_sum & sum_u);
    end

endmodule

// File: rtl/ripple_alu4.sv
// Module: ripple_alu4
// Top of the ripple ALU. One decoder feeds WIDTH identical bit cells that
// are chained through a ripple carry. Combinational: the outputs follow the
// inputs once the chain has settled.
module ripple_alu4
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [CODE_W-1:0] func_sel,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  result,
    output logic              carry_out
);

    localparam int CHAIN_N = WIDTH + 1;

    alu_ctl_t           ctl;
    logic [CHAIN_N-1:0] carry;

    alu_op_decoder u_dec (
        .code (func_sel),
        .ctl  (ctl)
    );

    // First carry: forced for subtraction, otherwise the external carry.
    always_comb begin
        carry[0] = ctl.force_cin | carry_in;
    end

    // Replicate the cell and chain each carry into the next.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        alu_bit_cell u_cell (
            .a    (op_a[gi]),
            .b    (op_b[gi]),
            .cin  (carry[gi]),
            .ctl  (ctl),
            .r    (result[gi]),
            .cout (carry[gi+1])
        );
    end

    // Carry leaves the block only when the adder is the selected unit.
    always_comb begin
        carry_out = carry[WIDTH] & ctl.en_sum;
    end

    // Port-level checks on the combined cells.
    always_comb begin
        assert_logic_no_carry_R1: assert (func_sel[1] || !carry_out)
            else $error("carry_out set in a logic mode");
        assert_sub_first_carry_R3: assert (func_sel != 2'd2 || carry[0])
            else $error("subtraction without forced carry");
        assert_add_sum_R4: assert (func_sel != 2'd3 ||
            {carry_out, result} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("add result mismatch");
        assert_and_word_R1: assert (func_sel != 2'd0 || result == (op_a & op_b))
            else $error("AND result mismatch");
    end

endmodule

// File: tb/test_ripple_alu4.sv
// Bench for ripple_alu4: exhaustive sweep per code, seeded random and
// directed corners, compared against reference functions.
module test_ripple_alu4;

    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   func_sel = '0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ripple_alu4 #(.WIDTH(W)) i_ripple_alu4 (
        .func_sel (func_sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .result   (result),
        .carry_out(carry_out)
    );

    // Reference: {carry, result} per the requirements.
    function automatic logic [W:0] ref_model(input logic [1:0] c, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic ci);
        logic [W:0] s;
        case (c)
            2'd0:    s = {1'b0, a & b};
            2'd1:    s = {1'b0, a | b};
            2'd2:    s = {1'b0, b} + {1'b0, ~a} + 1;
            default: s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        endcase
        return s;
    endfunction

    function automatic string req_of(input logic [1:0] c, input logic ci);
        case (c)
            2'd0: return ci ? "R1/R6" : "R1";
            2'd1: return ci ? "R2/R6" : "R2";
            2'd2: return ci ? "R3/R6/R7" : "R3/R7";
            default: return "R4/R7";
        endcase
    endfunction

    // Drive after a falling edge, sample 1 ns later (R8: same-cycle result).
    task automatic apply(input logic [1:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic ci);
        logic [W:0] exp_v;
        @(negedge clk);
        func_sel = c; op_a = a; op_b = b; carry_in = ci;
        #1;
        exp_v = ref_model(c, a, b, ci);
        n_cmp++;
        if ({carry_out, result} !== exp_v) begin
            n_bad++;
            $display("FAIL %s code=%0d a=%0d b=%0d cin=%0d actual=%0d/%0d expected=%0d/%0d",
                     req_of(c, ci), c, a, b, ci, carry_out, result, exp_v[W], exp_v[W-1:0]);
        end
    endtask

    // Watchdog: an expired timer counts as a failed check.
    initial begin
        #500000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs (all zero): AND of zeros, no carry (R1, R8).
        apply(2'd0, '0, '0, 1'b0);
        // Exhaustive sweep, both carry values: R1..R4, R6, R7.
        for (int c = 0; c < 4; c++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < M; a++)
                    for (int b = 0; b < M; b++)
                        apply(2'(c), W'(a), W'(b), 1'(ci));
        // Directed corners: borrow boundary R3, full carry ripple R4/R7.
        apply(2'd2, 4'd5, 4'd5, 1'b0);   // R3 equal: 0, carry 1
        apply(2'd2, 4'd6, 4'd5, 1'b1);   // R3 B<A: 15, carry 0
        apply(2'd3, 4'hF, 4'h0, 1'b1);   // R4 ripple through all cells
        apply(2'd3, 4'hF, 4'hF, 1'b1);   // R4 maximum
        // Seeded random mix (R5 exercised on every code via decoder check).
        for (int k = 0; k < 400; k++)
            apply(2'($urandom), W'($urandom), W'($urandom), 1'($urandom));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule